// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block gathers a set of external interrupt lines and turns each one into an interrupt message. Every line owns a programmable redirection entry. The entry sets the vector the message carries, a 3-bit delivery mode, a 16-bit destination identifier, the active polarity of the line, and whether the line is edge or level sensitive. A mask bit in the entry blocks the line. Messages leave through one output port with a valid/ready handshake.

Software reaches the register file indirectly. It writes an 8-bit index to the select location. The window location then reads or writes the chosen 32-bit register. A third location takes end-of-interrupt writes. Such a write carries a vector, and it re-arms every level-sensitive entry that is programmed with that vector. If the line is still active, the entry fires again.

Level-sensitive lines may be shared by several wired-OR sources, as long as those sources use the same polarity. An edge that arrives while its line is masked is lost for good.

Top module: `irt_ctrl`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000 (mask set, all other fields zero), every high word reads zero, and `msg_valid` is low.
- R2: Bus word addresses are 0 for select, 1 for window and 2 for end-of-interrupt. The low word of pin p sits at index 0x10+2p and the high word at index 0x11+2p. An unmapped index reads zero.
- R3: The low word holds the vector in bits 7:0, the delivery mode in bits 10:8, polarity in bit 13 (1 = active low), a read-only remote-pending flag in bit 14, trigger mode in bit 15 (1 = level) and the mask in bit 16. The high word holds the destination in bits 31:16. All other bits read zero.
- R4: Index 0x01 reads the version word: {8'h00, NUM_PINS-1, 8'h00, VERSION}. The default is 0x0007_0021.
- R5: An unmasked edge entry sends exactly one message per active-going transition of its polarity-corrected line. The message carries the entry's vector, delivery mode and destination.
- R6: An edge that arrives while the entry is masked is discarded. Clearing the mask afterwards produces no message.
- R7: An unmasked level entry whose line is active sends one message. Acceptance of that message sets the entry's remote-pending flag, and no further message is sent while the flag is set.
- R8: An end-of-interrupt write with a matching vector clears the remote-pending flag of each level entry programmed with that vector. If the line is still active, the entry fires again. A non-matching vector changes nothing.
- R9: With polarity set to active low, a level entry is pending while its line is held low and idle while the line is high.
- R10: When several entries request at the same time, the lowest-numbered pin is sent first. A presented message keeps its valid and its fields stable until `msg_ready` accepts it.
- R11: A read-modify-write of the low word that flips only bit 16 changes the mask and leaves every other field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Asynchronous interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 select, 1 window, 2 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the register chosen by the select index |
| msg_valid | output | 1 | Interrupt message presented |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination identifier |

## Verification
The bench raises an edge on a masked line and then unmasks it. A design that latched the edge would send a late message. It sends end-of-interrupt writes with a wrong vector and then the right one while a shared level line stays active. A design with broken vector matching would either re-arm on the wrong vector or never fire again. Two edge lines fire together while the consumer stalls. This exposes an arbiter that picks the wrong pin first, or that lets the fields change before the handshake completes. An all-ones write followed by a masking read-modify-write exposes misplaced fields and writes that spill onto neighbouring bits.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int IDX_W = 8;
    localparam logic [1:0] ADDR_SEL = 2'd0;
    localparam logic [1:0] ADDR_WIN = 2'd1;
    localparam logic [1:0] ADDR_EOI = 2'd2;
    localparam logic [IDX_W-1:0] IDX_VERSION  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_RTE_BASE = 8'h10;

    // low-word bit positions
    localparam int LO_DMODE  = 8;
    localparam int LO_POL    = 13;
    localparam int LO_REMOTE = 14;
    localparam int LO_LEVEL  = 15;
    localparam int LO_MASK   = 16;
    localparam int HI_DEST   = 16;

    typedef struct packed {
        logic [7:0]  vector;
        logic [2:0]  dmode;
        logic        pol;    // 1 = active low
        logic        level;  // 1 = level sensitive
        logic        mask;
        logic [15:0] dest;
    } rte_t;

    typedef struct packed {
        logic [7:0]  vector;
        logic [2:0]  dmode;
        logic [15:0] dest;
        logic        level;
    } msg_t;

    localparam rte_t RTE_RESET = '{vector: 8'h00, dmode: 3'd0, pol: 1'b0,
                                   level: 1'b0, mask: 1'b1, dest: 16'h0000};

    function automatic logic [31:0] pack_low(rte_t e, logic remote);
        logic [31:0] w;
        w = '0;
        w[7:0] = e.vector;
        w[LO_DMODE +: 3] = e.dmode;
        w[LO_POL] = e.pol;
        w[LO_REMOTE] = remote;
        w[LO_LEVEL] = e.level;
        w[LO_MASK] = e.mask;
        return w;
    endfunction

    function automatic logic [31:0] pack_high(rte_t e);
        return {e.dest, 16'h0000};
    endfunction

    function automatic rte_t unpack_low(rte_t old, logic [31:0] w);
        rte_t e;
        e = old;
        e.vector = w[7:0];
        e.dmode  = w[LO_DMODE +: 3];
        e.pol    = w[LO_POL];
        e.level  = w[LO_LEVEL];
        e.mask   = w[LO_MASK];
        return e;
    endfunction

    function automatic logic [31:0] version_word(logic [7:0] ver, logic [7:0] max_pin);
        return {8'h00, max_pin, 8'h00, ver};
    endfunction

endpackage

// File: rtl/irt_regfile.sv
module irt_regfile
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [NUM_PINS-1:0]  remote_i,
    output logic [31:0]          bus_rdata,
    output rte_t [NUM_PINS-1:0]  rte_o,
    output logic                 eoi_valid_o,
    output logic [7:0]           eoi_vector_o
);
    localparam int PW = $clog2(NUM_PINS);
    localparam int RTE_END = 16 + 2 * NUM_PINS;
    localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

    logic [IDX_W-1:0] sel_q;
    logic [IDX_W-1:0] rel;
    logic             win_is_rte;
    logic             win_hi;
    logic [PW-1:0]    win_pin;
    rte_t [NUM_PINS-1:0] rte_q;

    always_comb begin
        rel        = sel_q - IDX_RTE_BASE;
        win_is_rte = (int'(sel_q) >= int'(IDX_RTE_BASE)) && (int'(sel_q) < RTE_END);
        win_hi     = rel[0];
        win_pin    = rel[PW:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) rte_q[p] <= RTE_RESET;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_SEL) begin
                sel_q <= bus_wdata[IDX_W-1:0];
            end else if (bus_addr == ADDR_WIN && win_is_rte) begin
                if (win_hi) rte_q[win_pin].dest <= bus_wdata[HI_DEST +: 16];
                else        rte_q[win_pin] <= unpack_low(rte_q[win_pin], bus_wdata);
            end
        end
    end

    always_comb begin
        if (sel_q == IDX_VERSION)
            bus_rdata = version_word(VERSION, MAX_PIN);
        else if (win_is_rte)
            bus_rdata = win_hi ? pack_high(rte_q[win_pin])
                               : pack_low(rte_q[win_pin], remote_i[win_pin]);
        else
            bus_rdata = '0;
    end

    assign rte_o        = rte_q;
    assign eoi_valid_o  = bus_wr && (bus_addr == ADDR_EOI);
    assign eoi_vector_o = bus_wdata[7:0];

endmodule

// File: rtl/irt_pin_unit.sv
module irt_pin_unit
    import irt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  rte_t       cfg,
    input  logic       accept,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       req,
    output logic       remote
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       pend_q;
    logic       remote_q;
    logic       act;

    assign act = sync_q[1] ^ cfg.pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            prev_q   <= 1'b0;
            pend_q   <= 1'b0;
            remote_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_raw};
            prev_q <= act;
            // edge path: a masked edge is dropped, never stored
            if (cfg.mask || cfg.level)  pend_q <= 1'b0;
            else if (act && !prev_q)    pend_q <= 1'b1;
            else if (accept)            pend_q <= 1'b0;
            // level path: remote flag set on delivery, cleared by matching EOI
            if (!cfg.level)             remote_q <= 1'b0;
            else if (accept)            remote_q <= 1'b1;
            else if (eoi_valid && eoi_vector == cfg.vector) remote_q <= 1'b0;
        end
    end

    assign req    = cfg.level ? (act && !cfg.mask && !remote_q) : pend_q;
    assign remote = remote_q;

endmodule

// File: rtl/irt_arbiter.sv
module irt_arbiter
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  req_vec,
    input  rte_t [NUM_PINS-1:0]  rte_i,
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output msg_t                 msg_o,
    output logic [$clog2(NUM_PINS)-1:0] msg_pin,
    output logic [NUM_PINS-1:0]  accept_vec
);
    localparam int PW = $clog2(NUM_PINS);

    logic [PW-1:0] pick;
    logic          any_req;
    logic          valid_q;
    msg_t          msg_q;
    logic [PW-1:0] pin_q;

    always_comb begin
        pick = '0;
        for (int p = NUM_PINS - 1; p >= 0; p--)
            if (req_vec[p]) pick = PW'(p);
        any_req = |req_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
            pin_q   <= '0;
        end else if (valid_q && msg_ready) begin
            valid_q <= 1'b0;
        end else if (!valid_q && any_req) begin
            valid_q      <= 1'b1;
            pin_q        <= pick;
            msg_q.vector <= rte_i[pick].vector;
            msg_q.dmode  <= rte_i[pick].dmode;
            msg_q.dest   <= rte_i[pick].dest;
            msg_q.level  <= rte_i[pick].level;
        end
    end

    always_comb begin
        accept_vec = '0;
        if (valid_q && msg_ready) accept_vec[pin_q] = 1'b1;
    end

    assign msg_valid = valid_q;
    assign msg_o     = msg_q;
    assign msg_pin   = pin_q;

endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_dmode,
    output logic [15:0]         msg_dest
);
    localparam int PW = $clog2(NUM_PINS);

    rte_t [NUM_PINS-1:0] rte;
    logic [NUM_PINS-1:0] req_vec;
    logic [NUM_PINS-1:0] remote_vec;
    logic [NUM_PINS-1:0] accept_vec;
    logic [NUM_PINS-1:0] mask_vec;
    logic                eoi_valid;
    logic [7:0]          eoi_vector;
    msg_t                msg;
    logic [PW-1:0]       msg_pin;

    irt_regfile #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .remote_i(remote_vec), .bus_rdata(bus_rdata),
        .rte_o(rte), .eoi_valid_o(eoi_valid), .eoi_vector_o(eoi_vector)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irt_pin_unit u_pin (
            .clk(clk), .rst(rst), .pin_raw(irq_in[p]), .cfg(rte[p]),
            .accept(accept_vec[p]), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .req(req_vec[p]), .remote(remote_vec[p])
        );
        assign mask_vec[p] = rte[p].mask;
    end

    irt_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk(clk), .rst(rst), .req_vec(req_vec), .rte_i(rte),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_o(msg),
        .msg_pin(msg_pin), .accept_vec(accept_vec)
    );

    assign msg_vector = msg.vector;
    assign msg_dmode  = msg.dmode;
    assign msg_dest   = msg.dest;

endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        msg_valid,
    input logic                        msg_ready,
    input logic [7:0]                  msg_vector,
    input logic [2:0]                  msg_dmode,
    input logic [15:0]                 msg_dest,
    input logic                        msg_level,
    input logic [$clog2(NUM_PINS)-1:0] msg_pin,
    input logic [NUM_PINS-1:0]         req_vec,
    input logic [NUM_PINS-1:0]         mask_vec,
    input logic [NUM_PINS-1:0]         remote_vec
);
    // R1: reset clears the output port
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !msg_valid);

    // R10: a stalled message keeps valid and fields
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_dmode) && $stable(msg_dest)));

    // R10: a newly presented message comes from the lowest requesting pin
    a_r10_lowest_first: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> ((($past(req_vec) >> msg_pin) & 1) != 0 &&
                              ($past(req_vec) & ((NUM_PINS'(1) << msg_pin) - 1)) == 0));

    // R6: a masked entry holds no request in the following cycle
    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_vec & mask_vec & $past(mask_vec)) == '0));

    // R7: delivery of a level message sets the remote-pending flag
    a_r7_remote_set: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && msg_level) |=> (((remote_vec >> $past(msg_pin)) & 1) != 0));

endmodule

bind irt_ctrl irt_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_dest(msg_dest),
    .msg_level(msg.level), .msg_pin(msg_pin), .req_vec(req_vec),
    .mask_vec(mask_vec), .remote_vec(remote_vec)
);

// File: tb/irt_ctrl_tb_top.sv
module irt_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         msg_valid;
    logic         msg_ready = 1'b1;
    logic [7:0]   msg_vector;
    logic [2:0]   msg_dmode;
    logic [15:0]  msg_dest;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;  // 125 MHz

    irt_ctrl #(.NUM_PINS(N)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dmode(msg_dmode), .msg_dest(msg_dest)
    );

    // accepted-message monitor
    int          acc_cnt = 0;
    logic [7:0]  acc_vec [0:15];
    logic [2:0]  last_dmode = '0;
    logic [15:0] last_dest = '0;
    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            acc_vec[acc_cnt % 16] <= msg_vector;
            last_dmode <= msg_dmode;
            last_dest  <= msg_dest;
            acc_cnt    <= acc_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(2'd0, {24'h0, idx});
        bus_write(2'd1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(2'd0, {24'h0, idx});
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] lo_idx(input int p);
        return 8'(8'h10 + 2 * p);
    endfunction

    function automatic logic [7:0] hi_idx(input int p);
        return 8'(8'h11 + 2 * p);
    endfunction

    function automatic logic [31:0] lw(input logic [7:0] vec, input logic [2:0] dm,
                                       input logic pol, input logic lvl, input logic msk);
        return {15'b0, msk, lvl, 1'b0, pol, 2'b0, dm, vec};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 msg_valid after reset", {31'b0, msg_valid}, 32'h0);
        reg_read(lo_idx(0), d); chk("R1 low word pin0", d, 32'h0001_0000);
        reg_read(lo_idx(7), d); chk("R1 low word pin7", d, 32'h0001_0000);
        reg_read(hi_idx(3), d); chk("R1 high word pin3", d, 32'h0);
        reg_read(8'h01, d);     chk("R4 version word", d, 32'h0007_0021);
        reg_read(8'h40, d);     chk("R2 unmapped index", d, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        reg_write(lo_idx(2), 32'hFFFF_FFFF);
        reg_read(lo_idx(2), d); chk("R3 low field layout", d, 32'h0001_A7FF);
        reg_write(hi_idx(2), 32'hFFFF_FFFF);
        reg_read(hi_idx(2), d); chk("R3 high field layout", d, 32'hFFFF_0000);
        reg_read(lo_idx(3), d); chk("R2 neighbour untouched", d, 32'h0001_0000);
        reg_write(lo_idx(2), lw(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
        reg_write(hi_idx(2), 32'h0);
    endtask

    task automatic t_edge();
        int base;
        reg_write(hi_idx(1), 32'h1234_0000);
        reg_write(lo_idx(1), lw(8'h41, 3'd3, 1'b0, 1'b0, 1'b0));
        idle(4);
        base = acc_cnt;
        irq_in[1] = 1'b1;
        idle(15);
        chk("R5 one message per edge", 32'(acc_cnt - base), 32'd1);
        chk("R5 vector", {24'h0, acc_vec[base % 16]}, 32'h41);
        chk("R5 delivery mode", {29'h0, last_dmode}, 32'd3);
        chk("R5 destination", {16'h0, last_dest}, 32'h1234);
        idle(10);
        chk("R5 no repeat while high", 32'(acc_cnt - base), 32'd1);
        irq_in[1] = 1'b0;
        idle(5);
    endtask

    task automatic t_masked_edge();
        logic [31:0] v;
        logic [31:0] d;
        int base;
        reg_read(lo_idx(1), v);
        reg_write(lo_idx(1), v | 32'h0001_0000);
        reg_read(lo_idx(1), d); chk("R11 mask set only", d, v | 32'h0001_0000);
        base = acc_cnt;
        irq_in[1] = 1'b1;
        idle(10);
        reg_write(lo_idx(1), d & ~32'h0001_0000);
        reg_read(lo_idx(1), d); chk("R11 mask cleared only", d, v);
        idle(15);
        chk("R6 masked edge dropped", 32'(acc_cnt - base), 32'd0);
        irq_in[1] = 1'b0;
        idle(5);
    endtask

    task automatic t_level();
        logic [31:0] d;
        int base;
        reg_write(lo_idx(3), lw(8'h52, 3'd1, 1'b0, 1'b1, 1'b0));
        base = acc_cnt;
        irq_in[3] = 1'b1;
        idle(15);
        chk("R7 level fires once", 32'(acc_cnt - base), 32'd1);
        reg_read(lo_idx(3), d); chk("R7 remote flag set", d, lw(8'h52, 3'd1, 1'b0, 1'b1, 1'b0) | 32'h4000);
        bus_write(2'd2, 32'h53);
        idle(10);
        chk("R8 wrong vector no refire", 32'(acc_cnt - base), 32'd1);
        reg_read(lo_idx(3), d); chk("R8 wrong vector keeps remote", d[14], 1'b1);
        bus_write(2'd2, 32'h52);
        idle(10);
        chk("R8 matching EOI refires", 32'(acc_cnt - base), 32'd2);
        irq_in[3] = 1'b0;
        idle(5);
        bus_write(2'd2, 32'h52);
        idle(10);
        chk("R8 EOI with line idle no message", 32'(acc_cnt - base), 32'd2);
        reg_read(lo_idx(3), d); chk("R8 remote cleared", d, lw(8'h52, 3'd1, 1'b0, 1'b1, 1'b0));
    endtask

    task automatic t_polarity();
        int base;
        irq_in[4] = 1'b1;
        idle(4);
        reg_write(hi_idx(4), 32'hBEEF_0000);
        base = acc_cnt;
        reg_write(lo_idx(4), lw(8'h60, 3'd5, 1'b1, 1'b1, 1'b0));
        idle(10);
        chk("R9 active-low idle when high", 32'(acc_cnt - base), 32'd0);
        irq_in[4] = 1'b0;
        idle(10);
        chk("R9 active-low fires when low", 32'(acc_cnt - base), 32'd1);
        chk("R9 destination", {16'h0, last_dest}, 32'hBEEF);
        irq_in[4] = 1'b1;
        idle(5);
        bus_write(2'd2, 32'h60);
        idle(10);
        chk("R9 no message after release", 32'(acc_cnt - base), 32'd1);
    endtask

    task automatic t_priority();
        int base;
        msg_ready = 1'b0;
        reg_write(lo_idx(6), lw(8'h71, 3'd0, 1'b0, 1'b0, 1'b0));
        reg_write(lo_idx(5), lw(8'h70, 3'd0, 1'b0, 1'b0, 1'b0));
        idle(4);
        base = acc_cnt;
        irq_in[6:5] = 2'b11;
        idle(10);
        chk("R10 valid presented", {31'b0, msg_valid}, 32'd1);
        chk("R10 lowest pin first", {24'h0, msg_vector}, 32'h70);
        idle(5);
        chk("R10 held while stalled", {24'h0, msg_vector}, 32'h70);
        chk("R10 valid held", {31'b0, msg_valid}, 32'd1);
        msg_ready = 1'b1;
        idle(10);
        chk("R10 both delivered", 32'(acc_cnt - base), 32'd2);
        chk("R10 first accepted", {24'h0, acc_vec[base % 16]}, 32'h70);
        chk("R10 second accepted", {24'h0, acc_vec[(base + 1) % 16]}, 32'h71);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_fields();
        t_edge();
        t_masked_edge();
        t_level();
        t_polarity();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule